// File: doc/BRIEF.md
# Address-Decoded Bus Cycle Timer

This block runs one processor bus access at a time on a 24-bit address bus and decides how many master clocks that access takes. The length comes from a decode of the request address. Accesses in the ROM region use a configurable length. The other regions take 6, 8 or 12 clocks. A requester offers an idle, read or write operation through a valid/ready handshake. The block then counts out the cycle and raises a read strobe or a write strobe at a fixed clock inside it. It reports completion with a one-clock response pulse.

The block keeps a memory data latch that holds the last byte seen on the bus. When no device answers a read, the latch value is returned as the open-bus value. Reads from a small internal register window leave the latch alone. Two edge pulses mark fixed points in every cycle, so that DMA and ALU logic elsewhere can hook in.

Top module: `bus_cycle_timer`

## Requirements
- R1: A synchronous active-high reset clears `openBus` to 0x00 and raises `reqReady`. `rspValid`, `busRdStb`, `busWrStb`, `dmaEdge` and `aluEdge` are all low after reset.
- R2: A request is accepted on a clock where `reqValid` and `reqReady` are both high. From the next clock, `reqReady` stays low until the clock after `rspValid`, so only one access is in flight at a time.
- R3: Busy clocks are indexed from 0, starting with the first clock after acceptance. `rspValid` is high for exactly one clock, at index L-1, where L is the cycle length. `reqOp` encodes 0 = idle, 1 = read, 2 = write, 3 = idle. An idle operation has L = 6.
- R4: The cycle length of a read or write depends on the address. Write bank = addr[23:16] and offset = addr[15:0].
  - If addr[22] is set or the offset is 0x8000 or above, L is the ROM speed when addr[23] is set, and 8 when addr[23] is clear.
  - Otherwise L is 8 for offsets below 0x2000 or at 0x6000 and above.
  - Otherwise L is 12 for offsets 0x4000 to 0x41FF.
  - Otherwise L is 6.
- R5: The ROM speed is 6 when `cfgRomFast` is 1 and 8 when it is 0. The block samples `cfgRomFast` only on the clock that accepts the request.
- R6: A read raises `busRdStb` for exactly one clock, at index L-4, with `busAddr` equal to the request address. At `rspValid`, `rspData` holds the byte sampled at that clock. The byte is `busRdData` if `busRdDrive` was high, and otherwise the current `openBus` value.
- R7: A read loads the returned byte into `openBus`, except when the address satisfies (addr & 0x40FC00) == 0x004000. Those reads leave `openBus` unchanged.
- R8: A write raises `busWrStb` for exactly one clock, at index L-1, with `busAddr` and `busWrData` equal to the request. `openBus` then holds the written byte. Non-read operations never raise `busRdStb`.
- R9: `dmaEdge` is high for exactly one clock per access, at index 0.
- R10: `aluEdge` is high for exactly one clock per access. For idle and read operations it is at index L-1. For a write it is at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgRomFast | input | 1 | ROM speed select (1 = 6 clocks, 0 = 8 clocks) |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can accept a request |
| reqOp | input | 2 | Operation: 0 idle, 1 read, 2 write, 3 idle |
| reqAddr | input | 24 | Access address |
| reqWrData | input | 8 | Write byte |
| rspValid | output | 1 | Access completes this clock |
| rspData | output | 8 | Read result, valid with rspValid on reads |
| busAddr | output | 24 | Address of the access in flight |
| busWrData | output | 8 | Write byte of the access in flight |
| busRdStb | output | 1 | Read sample strobe |
| busWrStb | output | 1 | Write strobe |
| busRdData | input | 8 | Byte returned by a bus device |
| busRdDrive | input | 1 | A device drives busRdData |
| openBus | output | 8 | Memory data latch (open-bus value) |
| dmaEdge | output | 1 | DMA hook pulse |
| aluEdge | output | 1 | ALU hook pulse |

## Verification
The bench builds the block with its default parameters:
- cycle lengths of 6, 8 and 12 clocks,
- a read tail of 4 clocks,
- a 24-bit address.

It sweeps a grid of banks on either side of bits 22 and 23 against offsets at every decode boundary, with both ROM speed settings. This reaches every branch of the length decode, both edges of the register window, open-bus reads and the latch loads from writes. The ROM speed input is flipped during every busy cycle to show that only the value sampled at acceptance counts.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_NOP   = 2'd3
  } busOpE;

  typedef struct packed {
    logic capture;   // request accepted this clock
    logic sampleRd;  // sample read data this clock
    logic doWrite;   // drive write this clock
  } ctrlStrobesT;
endpackage

// File: rtl/bct_speed.sv
module bct_speed #(
  parameter int LEN_W       = 4,
  parameter int LEN_MID     = 8,
  parameter int LEN_SHORT   = 6,
  parameter int LEN_LONG    = 12,
  parameter int LEN_FASTROM = 6,
  parameter int LEN_SLOWROM = 8
) (
  input  logic             bankTop,   // address bit 23
  input  logic             bankRom,   // address bit 22
  input  logic [15:0]      offset,
  input  logic             romFast,
  output logic [LEN_W-1:0] len
);
  logic midHit;
  logic ioHit;

  assign midHit = ((({1'b0, offset[14:0]} + 16'h6000) & 16'h4000) != 16'h0000);
  assign ioHit  = (((offset[14:0] - 15'h4000) & 15'h7E00) != 15'h0000);

  always_comb begin
    if (bankRom || offset[15]) begin
      if (bankTop) len = romFast ? LEN_W'(LEN_FASTROM) : LEN_W'(LEN_SLOWROM);
      else         len = LEN_W'(LEN_MID);
    end else if (midHit) begin
      len = LEN_W'(LEN_MID);
    end else if (ioHit) begin
      len = LEN_W'(LEN_SHORT);
    end else begin
      len = LEN_W'(LEN_LONG);
    end
  end
endmodule

// File: rtl/bct_ctrl.sv
module bct_ctrl
  import bct_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int LEN_IDLE  = 6,
  parameter int READ_TAIL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [LEN_W-1:0] decLen,
  output logic             reqReady,
  output logic             rspValid,
  output logic             dmaEdge,
  output logic             aluEdge,
  output ctrlStrobesT      strb
);
  logic             busy;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] lenQ;
  busOpE            opQ;
  busOpE            opIn;
  logic             accept;
  logic             lastCyc;
  logic             firstCyc;

  assign opIn     = busOpE'(reqOp);
  assign reqReady = !busy;
  assign accept   = reqValid && !busy;
  assign firstCyc = busy && (cnt == '0);
  assign lastCyc  = busy && (cnt == lenQ - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      lenQ <= '0;
      opQ  <= OP_IDLE;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
      if (opIn == OP_READ || opIn == OP_WRITE) begin
        opQ  <= opIn;
        lenQ <= decLen;
      end else begin
        opQ  <= OP_IDLE;
        lenQ <= LEN_W'(LEN_IDLE);
      end
    end else if (busy) begin
      if (lastCyc) busy <= 1'b0;
      else         cnt  <= cnt + LEN_W'(1);
    end
  end

  assign rspValid      = lastCyc;
  assign dmaEdge       = firstCyc;
  assign aluEdge       = (opQ == OP_WRITE) ? firstCyc : lastCyc;
  assign strb.capture  = accept;
  assign strb.sampleRd = busy && (opQ == OP_READ) && (cnt == lenQ - LEN_W'(READ_TAIL));
  assign strb.doWrite  = lastCyc && (opQ == OP_WRITE);

  AST_ACCEPT_DMA: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> dmaEdge); // R9
  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> reqReady); // R2
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    dmaEdge |-> !reqReady); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < lenQ)); // R3
  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(strb.sampleRd && strb.doWrite)); // R8
endmodule

// File: rtl/bct_datapath.sv
module bct_datapath
  import bct_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobesT       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] busRdData,
  input  logic              busRdDrive,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              busRdStb,
  output logic              busWrStb,
  output logic [DATA_W-1:0] rspData,
  output logic [DATA_W-1:0] openBus
);
  localparam logic [ADDR_W-1:0] WIN_MASK  = ADDR_W'(24'h40FC00);
  localparam logic [ADDR_W-1:0] WIN_MATCH = ADDR_W'(24'h004000);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] mdrQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [DATA_W-1:0] rdVal;
  logic              inWindow;

  assign inWindow = ((addrQ & WIN_MASK) == WIN_MATCH);
  assign rdVal    = busRdDrive ? busRdData : mdrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      wrDataQ <= '0;
      mdrQ    <= '0;
      rdDataQ <= '0;
    end else begin
      if (strb.capture) begin
        addrQ   <= reqAddr;
        wrDataQ <= reqWrData;
      end
      if (strb.sampleRd) begin
        rdDataQ <= rdVal;
        if (!inWindow) mdrQ <= rdVal;
      end else if (strb.doWrite) begin
        mdrQ <= wrDataQ;
      end
    end
  end

  assign busAddr   = addrQ;
  assign busWrData = wrDataQ;
  assign busRdStb  = strb.sampleRd;
  assign busWrStb  = strb.doWrite;
  assign rspData   = rdDataQ;
  assign openBus   = mdrQ;

  AST_MDR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(strb.sampleRd || strb.doWrite) |=> $stable(mdrQ)); // R7
  AST_WINDOW_KEEP: assert property (@(posedge clk) disable iff (rst)
    (strb.sampleRd && inWindow) |=> $stable(mdrQ)); // R7
  AST_OPEN_BUS_KEEP: assert property (@(posedge clk) disable iff (rst)
    (strb.sampleRd && !busRdDrive) |=> $stable(mdrQ)); // R6
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
    strb.doWrite |=> (mdrQ == $past(wrDataQ))); // R8
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
  import bct_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 8,
  parameter int LEN_IDLE    = 6,
  parameter int LEN_MID     = 8,
  parameter int LEN_SHORT   = 6,
  parameter int LEN_LONG    = 12,
  parameter int LEN_FASTROM = 6,
  parameter int LEN_SLOWROM = 8,
  parameter int READ_TAIL   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgRomFast,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              busRdStb,
  output logic              busWrStb,
  input  logic [DATA_W-1:0] busRdData,
  input  logic              busRdDrive,
  output logic [DATA_W-1:0] openBus,
  output logic              dmaEdge,
  output logic              aluEdge
);
  localparam int LEN_W = $clog2(LEN_LONG + 1);

  logic [LEN_W-1:0] decLen;
  ctrlStrobesT      strb;

  bct_speed #(
    .LEN_W(LEN_W), .LEN_MID(LEN_MID), .LEN_SHORT(LEN_SHORT), .LEN_LONG(LEN_LONG),
    .LEN_FASTROM(LEN_FASTROM), .LEN_SLOWROM(LEN_SLOWROM)
  ) i_speed (
    .bankTop (reqAddr[ADDR_W-1]),
    .bankRom (reqAddr[ADDR_W-2]),
    .offset  (reqAddr[15:0]),
    .romFast (cfgRomFast),
    .len     (decLen)
  );

  bct_ctrl #(
    .LEN_W(LEN_W), .LEN_IDLE(LEN_IDLE), .READ_TAIL(READ_TAIL)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .decLen   (decLen),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .dmaEdge  (dmaEdge),
    .aluEdge  (aluEdge),
    .strb     (strb)
  );

  bct_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .reqWrData  (reqWrData),
    .busRdData  (busRdData),
    .busRdDrive (busRdDrive),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRdStb   (busRdStb),
    .busWrStb   (busWrStb),
    .rspData    (rspData),
    .openBus    (openBus)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (reqReady && openBus == '0 && !rspValid)); // R1
endmodule

// File: tb/test_bus_cycle_timer.sv
module test_bus_cycle_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgRomFast = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'd0;
  logic [23:0] reqAddr = '0;
  logic [7:0]  reqWrData = '0;
  logic        rspValid;
  logic [7:0]  rspData;
  logic [23:0] busAddr;
  logic [7:0]  busWrData;
  logic        busRdStb;
  logic        busWrStb;
  logic [7:0]  busRdData = '0;
  logic        busRdDrive = 1'b0;
  logic [7:0]  openBus;
  logic        dmaEdge;
  logic        aluEdge;

  int   errors = 0;
  int   checks = 0;
  int   cycles = 0;
  logic [7:0] expMdr = 8'h00;

  always #4 clk = ~clk;

  bus_cycle_timer i_bus_cycle_timer (
    .clk(clk), .rst(rst), .cfgRomFast(cfgRomFast), .reqValid(reqValid),
    .reqReady(reqReady), .reqOp(reqOp), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .rspValid(rspValid), .rspData(rspData), .busAddr(busAddr), .busWrData(busWrData),
    .busRdStb(busRdStb), .busWrStb(busWrStb), .busRdData(busRdData),
    .busRdDrive(busRdDrive), .openBus(openBus), .dmaEdge(dmaEdge), .aluEdge(aluEdge)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2 actual=%0d cycles expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Region rules written as bank/offset ranges
  function automatic int expLen(input logic [23:0] a, input bit fast);
    int off = int'(a[15:0]);
    if (a[22] || off >= 32'h8000) return a[23] ? (fast ? 6 : 8) : 8;
    if (off < 32'h2000 || off >= 32'h6000) return 8;
    if (off >= 32'h4000 && off < 32'h4200) return 12;
    return 6;
  endfunction

  function automatic bit inWin(input logic [23:0] a);
    return !a[22] && (a[15:10] == 6'b010000);
  endfunction

  task automatic doAccess(input logic [1:0] op, input logic [23:0] addr,
                          input logic [7:0] wd, input bit fast,
                          input bit drv, input logic [7:0] rv);
    bit isRd = (op == 2'd1);
    bit isWr = (op == 2'd2);
    int L = (isRd || isWr) ? expLen(addr, fast) : 6;
    logic [7:0] expRd = drv ? rv : expMdr;
    int rspK = -1, dmaK = -1, dmaCnt = 0, aluK = -1, aluCnt = 0;
    int rdK = -1, rdCnt = 0, wrK = -1, wrCnt = 0;
    bit rdAddrOk = 0, wrOk = 0, readyBad = 0;
    logic [7:0] rspD = '0;
    int expAluK = isWr ? 0 : L - 1;
    reqOp = op; reqAddr = addr; reqWrData = wd; cfgRomFast = fast;
    busRdDrive = drv; busRdData = rv; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cfgRomFast = !fast;   // R5: change after acceptance must not matter
    for (int k = 0; k < 20; k++) begin
      if (k > 0) @(negedge clk);
      if (reqReady) readyBad = 1;
      if (dmaEdge) begin dmaCnt++; dmaK = k; end
      if (aluEdge) begin aluCnt++; aluK = k; end
      if (busRdStb) begin rdCnt++; rdK = k; rdAddrOk = (busAddr == addr); end
      if (busWrStb) begin wrCnt++; wrK = k; wrOk = (busAddr == addr) && (busWrData == wd); end
      if (rspValid) begin rspK = k; rspD = rspData; break; end
    end
    @(negedge clk);
    chk(rspK == L - 1, (isRd || isWr) ? "R4/R5 length" : "R3 idle length", rspK, L - 1);
    chk(dmaCnt == 1 && dmaK == 0, "R9 dma edge", dmaK, 0);
    chk(aluCnt == 1 && aluK == expAluK, "R10 alu edge", aluK, expAluK);
    if (isRd) chk(rdCnt == 1 && rdK == L - 4 && rdAddrOk, "R6 read strobe", rdK, L - 4);
    else      chk(rdCnt == 0, "R8 no read strobe", rdCnt, 0);
    if (isWr) chk(wrCnt == 1 && wrK == L - 1 && wrOk, "R8 write strobe", wrK, L - 1);
    else      chk(wrCnt == 0, "R8 no write strobe", wrCnt, 0);
    if (isRd) chk(rspD == expRd, "R6 read data", rspD, expRd);
    chk(!readyBad && reqReady, "R2 one in flight", readyBad, 0);
    if (isWr) expMdr = wd;
    else if (isRd && !inWin(addr)) expMdr = expRd;
    chk(openBus == expMdr, "R7/R8 open bus latch", openBus, expMdr);
  endtask

  initial begin
    logic [7:0] banks [8];
    logic [15:0] offs [14];
    int idx = 0;
    banks = '{8'h00, 8'h3F, 8'h40, 8'h7E, 8'h80, 8'hBF, 8'hC0, 8'hFF};
    offs  = '{16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000, 16'h41FF, 16'h4200,
              16'h43FF, 16'h4400, 16'h5FFF, 16'h6000, 16'h7FFF, 16'h8000, 16'hFFFF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1 ready", reqReady, 1);
    chk(openBus == 8'h00, "R1 latch", openBus, 0);
    chk(!rspValid && !busRdStb && !busWrStb && !dmaEdge && !aluEdge, "R1 quiet",
        {rspValid, busRdStb, busWrStb, dmaEdge, aluEdge}, 0);

    // R3 idle encodings
    doAccess(2'd0, 24'h123456, 8'h00, 1'b0, 1'b1, 8'h77);
    doAccess(2'd3, 24'hC08000, 8'h00, 1'b1, 1'b1, 8'h77);

    // R6 open bus and R7 window
    doAccess(2'd2, 24'h7E0000, 8'h5A, 1'b0, 1'b0, 8'h00);
    doAccess(2'd1, 24'h000000, 8'h00, 1'b0, 1'b0, 8'hEE);
    doAccess(2'd1, 24'h004000, 8'h00, 1'b0, 1'b1, 8'h33);
    doAccess(2'd1, 24'h8043FF, 8'h00, 1'b0, 1'b0, 8'h44);
    doAccess(2'd1, 24'h404000, 8'h00, 1'b1, 1'b1, 8'h99);

    // R4/R5 sweep over bank x offset boundaries and both ROM speeds
    for (int b = 0; b < 8; b++) begin
      for (int o = 0; o < 14; o++) begin
        for (int f = 0; f < 2; f++) begin
          logic [1:0] op = (idx % 4 == 3) ? 2'd2 : 2'd1;
          doAccess(op, {banks[b], offs[o]}, 8'(idx ^ 8'hA5), f[0],
                   (idx % 3) != 0, 8'(idx * 37 + 5));
          idx++;
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule